// File: doc/BRIEF.md
# Serial-Parallel IO Bridge

This block joins a bit-serial, time-multiplexed logic fabric to a wide parallel system bus. The fabric runs in frames of eight ticks, and every serial wire carries a different net in each tick. The bridge takes the place of one four-block cluster and looks to the fabric like 32 LUT positions. In one direction it serializes up to 32 parallel system inputs onto a 4-wire serial bus, so 4 wires times 8 ticks give 32 nets. In the other direction it receives a 6-wire serial bus, which carries 48 nets per frame, and drives up to 48 registered parallel outputs.

Both directions are steered by per-tick selector tables held in a single configuration shift chain, loaded one bit per clock. On the serializer side, each (wire, tick) slot has a selector that picks one of the held parallel inputs. The parallel inputs are captured once per frame, so all values sent in one frame come from the same sample. On the deserializer side, each parallel output has a source code made of a wire index and a tick, plus an enable bit. An output updates only in the tick named by its code and holds its value at all other times.

Top module: `ser_par_bridge`

## Requirements
- R1: While `rst_n` is low, at the next clock edge `tick` becomes 0, `par_out` becomes all zeros, the held input sample is cleared so `ser_out` reads 0, and every configuration bit is cleared.
- R2: After reset, `tick` counts 0,1,...,7 one step per clock and wraps from 7 to 0.
- R3: While `cfg_shift` is high, each clock shifts the configuration chain one place toward bit 0 and writes `cfg_din` into the top bit (bit 495). The first bit shifted in after 496 shifts therefore lands in bit 0. Serializer selector (tick t, wire w) occupies chain bits [(t*4+w)*5 +: 5]. Output entry j occupies bits [160+7*j +: 7].
- R4: During a cycle in which `tick` equals t, `ser_out[w]` equals bit s of the held input sample, where s is the 5-bit selector for (t, w).
- R5: The held input sample is loaded from `par_in` at the clock edge that ends a tick-7 cycle. Changes on `par_in` at any other time do not affect `ser_out` before the next such edge.
- R6: In output entry j, bits [2:0] name a tick, bits [5:3] name a wire and bit 6 is the enable. When the enable is 1, the wire code is below 6 and `cfg_shift` is low, `par_out[j]` takes `ser_in[wire]` at the edge that ends the cycle in which `tick` equals the coded tick.
- R7: An output whose enable bit is 0, or whose wire code is 6 or 7, never changes.
- R8: While `cfg_shift` is high no parallel output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_shift | input | 1 | Shift one configuration bit in this cycle |
| cfg_din | input | 1 | Serial configuration data |
| par_in | input | 32 | Parallel system inputs |
| ser_out | output | 4 | Serial bus toward the fabric |
| ser_in | input | 6 | Serial bus from the fabric |
| par_out | output | 48 | Registered parallel system outputs |
| tick | output | 3 | Current tick within the eight-tick frame |

## Verification
The assertions check on every cycle that the tick sequence wraps correctly, that reset clears the outputs, and that the parallel outputs are frozen during configuration shifting. Only the bench's scenarios can show that the selector tables are decoded at the right chain positions and that serial bits come from the right held input. The same holds for captures landing in exactly the coded tick, for wire codes 6 and 7 and disabled entries never capturing, and for a mid-frame change on the parallel inputs leaving the current frame untouched. For these, the bench runs a lockstep model built from the requirements and compares against it each cycle, with random configurations and traffic.

// File: rtl/sp_bridge_pkg.sv
// Package: default geometry of the serial-parallel bridge and a width helper.
// Assumes the frame length and the parallel input count are powers of two.
package sp_bridge_pkg;
    localparam int unsigned DEF_TICKS     = 8;
    localparam int unsigned DEF_PAR_IN    = 32;
    localparam int unsigned DEF_SER_OUT   = 4;
    localparam int unsigned DEF_SER_IN    = 6;
    localparam int unsigned DEF_PAR_OUT   = 48;

    // Width of an index able to address n items (at least 1 bit).
    function automatic int unsigned idx_w(input int unsigned n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction
endpackage

// File: rtl/sp_tick_gen.sv
// Tick generator: counts the position within the serial frame.
// Assumes a synchronous active-low reset; restarts the frame at tick 0.
module sp_tick_gen #(
    parameter int unsigned TICKS = 8,
    localparam int unsigned TW   = sp_bridge_pkg::idx_w(TICKS)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [TW-1:0] tick,
    output logic          last
);
    localparam logic [TW-1:0] LAST_T = TW'(TICKS - 1);

    // Flag the final tick of the frame.
    always_comb last = (tick == LAST_T);

    // Advance the tick, wrapping at the end of the frame.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tick <= '0;
        else if (last)
            tick <= '0;
        else
            tick <= tick + TW'(1);
    end
endmodule

// File: rtl/sp_cfg_chain.sv
// Configuration chain: a serial-in shift register holding all selector tables.
// Assumes one bit enters per enabled clock, at the top, moving toward bit 0.
module sp_cfg_chain #(
    parameter int unsigned LEN = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           shift,
    input  logic           din,
    output logic [LEN-1:0] bits
);
    // Clear on reset, shift one place when requested.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bits <= '0;
        else if (shift)
            bits <= {din, bits[LEN-1:1]};
    end
endmodule

// File: rtl/sp_ser_tx.sv
// Serializer: samples the parallel inputs once per frame and, in each tick,
// drives every serial wire with the held input named by its per-tick selector.
// Assumes N_IN is a power of two so every selector code addresses an input.
module sp_ser_tx #(
    parameter int unsigned TICKS   = 8,
    parameter int unsigned N_IN    = 32,
    parameter int unsigned N_WIRES = 4,
    localparam int unsigned TW     = sp_bridge_pkg::idx_w(TICKS),
    localparam int unsigned SW     = sp_bridge_pkg::idx_w(N_IN),
    localparam int unsigned BITS   = TICKS * N_WIRES * SW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               last,
    input  logic [TW-1:0]      tick,
    input  logic [N_IN-1:0]    par_in,
    input  logic [BITS-1:0]    sel_bits,
    output logic [N_WIRES-1:0] ser_out
);
    logic [N_IN-1:0] held;
    logic [SW-1:0]   sel_tab [TICKS][N_WIRES];

    // Capture a coherent input sample as the frame ends.
    always_ff @(posedge clk) begin
        if (!rst_n)
            held <= '0;
        else if (last)
            held <= par_in;
    end

    // Unpack the flat selector table and build one mux per wire.
    for (genvar t = 0; t < TICKS; t++) begin : g_tick
        for (genvar w = 0; w < N_WIRES; w++) begin : g_slot
            assign sel_tab[t][w] = sel_bits[(t*N_WIRES + w)*SW +: SW];
        end
    end

    for (genvar w = 0; w < N_WIRES; w++) begin : g_wire
        // Pick the held input for this wire in the current tick.
        always_comb ser_out[w] = held[sel_tab[tick][w]];
    end
endmodule

// File: rtl/sp_par_rx.sv
// Deserializer: each parallel output watches one (wire, tick) slot of the
// serial bus and registers that bit when the slot comes by.
// Assumes entry layout {enable, wire, tick}; wire codes past N_WIRES never match.
module sp_par_rx #(
    parameter int unsigned TICKS   = 8,
    parameter int unsigned N_WIRES = 6,
    parameter int unsigned N_OUT   = 48,
    localparam int unsigned TW     = sp_bridge_pkg::idx_w(TICKS),
    localparam int unsigned WW     = sp_bridge_pkg::idx_w(N_WIRES),
    localparam int unsigned ENT    = TW + WW + 1,
    localparam int unsigned BITS   = N_OUT * ENT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               freeze,
    input  logic [TW-1:0]      tick,
    input  logic [N_WIRES-1:0] ser_in,
    input  logic [BITS-1:0]    ent_bits,
    output logic [N_OUT-1:0]   par_out
);
    localparam int unsigned PADW = 1 << WW;
    localparam logic [WW:0] WIRE_LIM = (WW+1)'(N_WIRES);

    logic [PADW-1:0] ser_pad;

    // Widen the serial bus so every wire code indexes a defined bit.
    always_comb begin
        ser_pad = '0;
        ser_pad[N_WIRES-1:0] = ser_in;
    end

    for (genvar j = 0; j < N_OUT; j++) begin : g_out
        logic [ENT-1:0] ent;
        logic [TW-1:0]  e_tick;
        logic [WW-1:0]  e_wire;
        logic           e_en;
        logic           hit;

        // Split this output's entry and decide whether it captures now.
        always_comb begin
            ent    = ent_bits[j*ENT +: ENT];
            e_tick = ent[TW-1:0];
            e_wire = ent[TW +: WW];
            e_en   = ent[ENT-1];
            hit    = e_en && !freeze && (e_tick == tick)
                     && ({1'b0, e_wire} < WIRE_LIM);
        end

        // Register the selected serial bit in its slot, hold otherwise.
        always_ff @(posedge clk) begin
            if (!rst_n)
                par_out[j] <= 1'b0;
            else if (hit)
                par_out[j] <= ser_pad[e_wire];
        end
    end
endmodule

// File: rtl/ser_par_bridge.sv
// Serial-parallel bridge top: ties the tick generator, configuration chain,
// serializer and deserializer together. The chain holds the serializer table
// in its low part and the deserializer entries above it.
// Assumes a synchronous active-low reset shared with the fabric frame.
module ser_par_bridge #(
    parameter int unsigned TICKS    = sp_bridge_pkg::DEF_TICKS,
    parameter int unsigned N_PAR_IN = sp_bridge_pkg::DEF_PAR_IN,
    parameter int unsigned N_SO     = sp_bridge_pkg::DEF_SER_OUT,
    parameter int unsigned N_SI     = sp_bridge_pkg::DEF_SER_IN,
    parameter int unsigned N_PO     = sp_bridge_pkg::DEF_PAR_OUT,
    localparam int unsigned TW      = sp_bridge_pkg::idx_w(TICKS),
    localparam int unsigned SW      = sp_bridge_pkg::idx_w(N_PAR_IN),
    localparam int unsigned WW      = sp_bridge_pkg::idx_w(N_SI),
    localparam int unsigned TX_BITS = TICKS * N_SO * SW,
    localparam int unsigned RX_BITS = N_PO * (TW + WW + 1),
    localparam int unsigned CFG_LEN = TX_BITS + RX_BITS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_shift,
    input  logic                cfg_din,
    input  logic [N_PAR_IN-1:0] par_in,
    output logic [N_SO-1:0]     ser_out,
    input  logic [N_SI-1:0]     ser_in,
    output logic [N_PO-1:0]     par_out,
    output logic [TW-1:0]       tick
);
    logic               last;
    logic [CFG_LEN-1:0] cfg;

    sp_tick_gen #(.TICKS(TICKS)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .last  (last)
    );

    sp_cfg_chain #(.LEN(CFG_LEN)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .shift (cfg_shift),
        .din   (cfg_din),
        .bits  (cfg)
    );

    sp_ser_tx #(.TICKS(TICKS), .N_IN(N_PAR_IN), .N_WIRES(N_SO)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .last     (last),
        .tick     (tick),
        .par_in   (par_in),
        .sel_bits (cfg[TX_BITS-1:0]),
        .ser_out  (ser_out)
    );

    sp_par_rx #(.TICKS(TICKS), .N_WIRES(N_SI), .N_OUT(N_PO)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .freeze   (cfg_shift),
        .tick     (tick),
        .ser_in   (ser_in),
        .ent_bits (cfg[CFG_LEN-1:TX_BITS]),
        .par_out  (par_out)
    );
endmodule

// File: rtl/sp_bridge_chk.sv
// Checker for the bridge top: frame counting, reset values and output
// freezing during configuration. Attached to every instance by bind.
module sp_bridge_chk #(
    parameter int unsigned TW   = 3,
    parameter int unsigned NSO  = 4,
    parameter int unsigned NPO  = 48,
    parameter int unsigned LAST = 7
) (
    input logic           clk,
    input logic           rst_n,
    input logic           cfg_shift,
    input logic [TW-1:0]  tick,
    input logic [NSO-1:0] ser_out,
    input logic [NPO-1:0] par_out
);
    localparam logic [TW-1:0] LAST_T = TW'(LAST);

    // R2: tick wraps from the last tick to 0
    p_tick_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick == LAST_T) |=> (tick == '0));

    // R2: tick steps by one elsewhere in the frame
    p_tick_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick != LAST_T) |=> (tick == $past(tick) + TW'(1)));

    // R1: reset clears tick and parallel outputs
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (tick == '0 && par_out == '0));

    // R1: reset clears the held sample, so the serial bus reads zero
    p_reset_ser_r1: assert property (@(posedge clk)
        !rst_n |=> (ser_out == '0));

    // R8: no parallel output moves while configuration is shifting
    p_freeze_cfg_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_shift |=> $stable(par_out));
endmodule

bind ser_par_bridge sp_bridge_chk #(
    .TW   (TW),
    .NSO  (N_SO),
    .NPO  (N_PO),
    .LAST (TICKS - 1)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_shift (cfg_shift),
    .tick      (tick),
    .ser_out   (ser_out),
    .par_out   (par_out)
);

// File: tb/sim_ser_par_bridge.sv
module sim_ser_par_bridge;
    localparam int TX_BITS = 160;
    localparam int CFG_LEN = 496;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_shift = 1'b0;
    logic        cfg_din = 1'b0;
    logic [31:0] par_in = '0;
    logic [5:0]  ser_in = '0;
    logic [3:0]  ser_out;
    logic [47:0] par_out;
    logic [2:0]  tick;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Model state, built from the requirements
    logic [CFG_LEN-1:0] m_cfg = '0;
    logic [2:0]         m_tick = '0;
    logic [31:0]        m_hold = '0;
    logic [47:0]        m_out = '0;
    logic [CFG_LEN-1:0] cfg_a;

    always #5 clk = ~clk;

    ser_par_bridge u0 (
        .clk(clk), .rst_n(rst_n), .cfg_shift(cfg_shift), .cfg_din(cfg_din),
        .par_in(par_in), .ser_out(ser_out), .ser_in(ser_in),
        .par_out(par_out), .tick(tick)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // R4: expected serial bus from held sample, selector table and tick
    function automatic logic [3:0] exp_ser(input logic [CFG_LEN-1:0] c,
                                           input logic [31:0] h, input logic [2:0] t);
        logic [3:0] r;
        for (int w = 0; w < 4; w++) begin
            logic [4:0] s;
            s = c[(int'(t)*4 + w)*5 +: 5];
            r[w] = h[s];
        end
        return r;
    endfunction

    // One cycle: check at the negedge, drive, advance the model
    task automatic step(input logic [31:0] pi, input logic [5:0] si,
                        input logic sh, input logic d);
        check("R2 tick", {61'b0, tick}, {61'b0, m_tick});
        check("R4 ser_out", {60'b0, ser_out}, {60'b0, exp_ser(m_cfg, m_hold, m_tick)});
        check(sh ? "R8 par_out" : "R6 par_out", {16'b0, par_out}, {16'b0, m_out});
        par_in = pi; ser_in = si; cfg_shift = sh; cfg_din = d;
        if (!sh) begin
            for (int j = 0; j < 48; j++) begin
                logic [6:0] e;
                e = m_cfg[TX_BITS + j*7 +: 7];
                if (e[6] && e[2:0] == m_tick && e[5:3] < 3'd6)
                    m_out[j] = si[e[5:3]];
            end
        end
        if (m_tick == 3'd7) m_hold = pi;
        m_tick = m_tick + 3'd1;
        if (sh) m_cfg = {d, m_cfg[CFG_LEN-1:1]};
        @(negedge clk);
    endtask

    task automatic run_idle(input int n);
        for (int i = 0; i < n; i++) step($urandom, 6'($urandom), 1'b0, 1'b0);
    endtask

    // R3: chain layout, first shifted bit ends at bit 0
    function automatic logic [CFG_LEN-1:0] make_cfg(input bit directed);
        logic [CFG_LEN-1:0] c;
        for (int k = 0; k < 32; k++) c[k*5 +: 5] = 5'($urandom);
        for (int j = 0; j < 48; j++) c[TX_BITS + j*7 +: 7] = 7'($urandom);
        if (directed) begin
            c[4:0] = 5'd31;                            // tick 0 wire 0 -> input 31
            c[9:5] = 5'd0;                             // tick 0 wire 1 -> input 0
            c[TX_BITS + 0*7 +: 7] = {1'b1, 3'd6, 3'd2}; // wire code 6
            c[TX_BITS + 1*7 +: 7] = {1'b0, 3'd2, 3'd3}; // disabled
            c[TX_BITS + 2*7 +: 7] = {1'b1, 3'd7, 3'd5}; // wire code 7
            c[TX_BITS + 3*7 +: 7] = {1'b1, 3'd5, 3'd4}; // wire 5 tick 4
        end
        return c;
    endfunction

    task automatic load_cfg(input logic [CFG_LEN-1:0] c);
        for (int i = 0; i < CFG_LEN; i++) step($urandom, 6'($urandom), 1'b1, c[i]);
    endtask

    initial begin
        void'($urandom(32'h5eed));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 tick", {61'b0, tick}, 64'd0);
        check("R1 ser_out", {60'b0, ser_out}, 64'd0);
        check("R1 par_out", {16'b0, par_out}, 64'd0);
        rst_n = 1'b1;

        // Unconfigured: every slot picks input 0, no output enabled
        run_idle(20);
        check("R7 unconfigured par_out", {16'b0, par_out}, 64'd0);

        cfg_a = make_cfg(1'b1);
        load_cfg(cfg_a);
        check("R3 chain contents via outputs", {16'b0, par_out}, 64'd0);
        while (m_tick != 3'd0) step($urandom, 6'($urandom), 1'b0, 1'b0);
        check("R3 slot t0 w0 selects input 31", {63'b0, ser_out[0]}, {63'b0, m_hold[31]});
        check("R3 slot t0 w1 selects input 0", {63'b0, ser_out[1]}, {63'b0, m_hold[0]});

        run_idle(8 * 30);
        check("R7 wire 6/7 and disabled entries hold", {61'b0, par_out[2:0]}, 64'd0);

        // R5: all-ones sampled at frame end, zeros afterwards must not leak
        while (m_tick != 3'd7) step($urandom, 6'($urandom), 1'b0, 1'b0);
        step(32'hFFFF_FFFF, 6'($urandom), 1'b0, 1'b0);
        for (int i = 0; i < 8; i++) begin
            check("R5 frame coherent", {60'b0, ser_out}, 64'hF);
            step(32'h0, 6'($urandom), 1'b0, 1'b0);
        end

        // R6: directed capture of wire 5 at tick 4 into output 3
        while (m_tick != 3'd4) step($urandom, 6'($urandom), 1'b0, 1'b0);
        step($urandom, 6'b100000, 1'b0, 1'b0);
        check("R6 output 3 captured", {63'b0, par_out[3]}, 64'd1);
        while (m_tick != 3'd4) step($urandom, 6'b100000, 1'b0, 1'b0);
        step($urandom, 6'b011111, 1'b0, 1'b0);
        check("R6 output 3 recaptured", {63'b0, par_out[3]}, 64'd0);

        // Second random configuration, loaded mid-traffic
        load_cfg(make_cfg(1'b0));
        run_idle(8 * 20);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #1_500_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule